// File: doc/BRIEF.md
# Signed Sequential Multiplier by Magnitude Conversion

This block multiplies two two's-complement operands of `N` bits each and returns a signed `2N`-bit product. It takes the absolute value of each operand and multiplies the two magnitudes with an unsigned shift-add datapath that retires one multiplier bit per cycle. If the operand signs differ, it then negates the unsigned result. A one-cycle `start_i` strobe launches an operation. A one-cycle `done_o` pulse marks the cycle in which `product_o` first shows the new result, and the product holds until the next result arrives.

The magnitudes are kept as unsigned `N`-bit values, so `|-2^(N-1)| = 2^(N-1)` fits exactly. The accumulator's upper half is `N+1` bits wide so the partial sums never wrap. While an operation is in flight the block ignores further strobes. The caller may start the next operation in the same cycle that `done_o` is high.

Top module: `smul_top`

## Requirements
- R1: After reset, `product_o` is all zeros and `done_o` is low.
- R2: When `start_i` is sampled high at a clock edge while the block is idle, `done_o` goes high after the `N+1`-th following edge and stays high for exactly one cycle.
- R3: With both operands non-negative, `product_o` equals their product as a `2N`-bit two's-complement value.
- R4: With `mcand_i` negative and `mplier_i` non-negative, `product_o` equals the negative signed product.
- R5: With `mcand_i` non-negative and `mplier_i` negative, `product_o` equals the negative signed product.
- R6: With both operands negative, `product_o` equals the positive signed product.
- R7: An operand equal to `-2^(N-1)` (MSB 1, all other bits 0) yields the exact signed product. This includes `(-2^(N-1))*(-2^(N-1)) = 2^(2N-2)`.
- R8: Whenever one operand is zero, `product_o` is all zeros, whatever the other operand's sign.
- R9: A `start_i` pulse that arrives while an operation is in flight has no effect. No extra `done_o` pulse follows, and the running result is not disturbed.
- R10: `product_o` changes only in a cycle where `done_o` is high, and it otherwise holds its last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Launch strobe, sampled when idle |
| mcand_i | input | N | Signed multiplicand |
| mplier_i | input | N | Signed multiplier |
| product_o | output | 2N | Signed product, held between results |
| done_o | output | 1 | One-cycle result-valid pulse |

## Verification
The bench builds two instances, one with `N = 4` and one with `N = 8`. At `N = 4` all 256 operand pairs fit in a short run, so every sign combination, every zero case and the most negative value are each covered exhaustively. The `N = 8` instance targets corners whose magnitudes reach into the wider accumulator, such as `-128*-128` and `-128*127`, plus a pseudo-random sweep. Busy-time strobes and hold-between-results checks run on both widths.

// File: rtl/smul_pkg.sv
package smul_pkg;

    typedef enum logic [1:0] {
        CORE_IDLE = 2'd0,
        CORE_RUN  = 2'd1,
        CORE_DONE = 2'd2
    } core_state_e;

endpackage

// File: rtl/smul_sign_prep.sv
module smul_sign_prep #(
    parameter int N = 4
) (
    input  logic [N-1:0] op_i,
    output logic [N-1:0] mag_o,
    output logic         neg_o
);
    localparam logic [N-1:0] MIN_VAL = {1'b1, {(N-1){1'b0}}};

    logic [N-1:0] inv_plus_one;

    always_comb begin
        inv_plus_one = (~op_i) + {{(N-1){1'b0}}, 1'b1};
        neg_o        = op_i[N-1];
        mag_o        = op_i[N-1] ? inv_plus_one : op_i;
    end

    // Magnitude MSB may be set only for the most negative input.
    always_comb begin
        if (!$isunknown(op_i)) begin
            AST_MAG_MSB_MIN_ONLY: assert (!mag_o[N-1] || (op_i == MIN_VAL)); // R7
        end
    end

endmodule

// File: rtl/smul_shift_add_core.sv
module smul_shift_add_core
    import smul_pkg::*;
#(
    parameter int N = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [N-1:0]  mcand_mag_i,
    input  logic [N-1:0]  mplier_mag_i,
    output logic          idle_o,
    output logic          done_o,
    output logic [2*N-1:0] raw_o
);
    localparam int AW = 2 * N + 1;
    localparam int CW = $clog2(N + 1);
    localparam logic [CW-1:0] LAST = CW'(N - 1);

    typedef struct packed {
        core_state_e    state;
        logic [CW-1:0]  cnt;
        logic [N-1:0]   mcand;
        logic [AW-1:0]  acc;
    } core_reg_t;

    core_reg_t r_q, r_d;
    logic [N:0] hi_sum;

    always_comb begin
        r_d    = r_q;
        hi_sum = r_q.acc[AW-1:N] + (r_q.acc[0] ? {1'b0, r_q.mcand} : '0);
        unique case (r_q.state)
            CORE_IDLE: begin
                if (start_i) begin
                    r_d.state = CORE_RUN;
                    r_d.cnt   = '0;
                    r_d.mcand = mcand_mag_i;
                    r_d.acc   = {{(N+1){1'b0}}, mplier_mag_i};
                end
            end
            CORE_RUN: begin
                r_d.acc = {hi_sum, r_q.acc[N-1:0]} >> 1;
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == LAST) begin
                    r_d.state = CORE_DONE;
                end
            end
            CORE_DONE: begin
                r_d.state = CORE_IDLE;
            end
            default: r_d.state = CORE_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '{state: CORE_IDLE, cnt: '0, mcand: '0, acc: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign idle_o = (r_q.state == CORE_IDLE);
    assign done_o = (r_q.state == CORE_DONE);
    assign raw_o  = r_q.acc[2*N-1:0];

    AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.state == CORE_RUN) |-> (r_q.cnt < CW'(N))); // R2
    AST_IDLE_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
        (idle_o && start_i) |=> (r_q.state == CORE_RUN) && (r_q.cnt == '0)); // R2
    AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle_o && start_i) |=> $stable(r_q.mcand)); // R9
    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> idle_o); // R2

endmodule

// File: rtl/smul_sign_fix.sv
module smul_sign_fix #(
    parameter int N = 4
) (
    input  logic [2*N-1:0] raw_i,
    input  logic           neg_i,
    output logic [2*N-1:0] fixed_o
);
    always_comb begin
        fixed_o = neg_i ? ((~raw_i) + {{(2*N-1){1'b0}}, 1'b1}) : raw_i;
    end

    // Negating zero must yield zero.
    always_comb begin
        if (!$isunknown({raw_i, neg_i}) && raw_i == '0) begin
            AST_FIX_ZERO_STAYS_ZERO: assert (fixed_o == '0); // R8
        end
    end

endmodule

// File: rtl/smul_top.sv
module smul_top
    import smul_pkg::*;
#(
    parameter int N = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           start_i,
    input  logic [N-1:0]   mcand_i,
    input  logic [N-1:0]   mplier_i,
    output logic [2*N-1:0] product_o,
    output logic           done_o
);
    localparam int PW = 2 * N;

    typedef struct packed {
        logic          neg;
        logic          done;
        logic [PW-1:0] product;
    } top_reg_t;

    top_reg_t r_q, r_d;

    logic [N-1:0]  mag_a, mag_b;
    logic          sgn_a, sgn_b;
    logic          core_idle, core_done;
    logic [PW-1:0] core_raw, fixed;
    logic          accept;

    smul_sign_prep #(.N(N)) u_prep_mcand (
        .op_i  (mcand_i),
        .mag_o (mag_a),
        .neg_o (sgn_a)
    );

    smul_sign_prep #(.N(N)) u_prep_mplier (
        .op_i  (mplier_i),
        .mag_o (mag_b),
        .neg_o (sgn_b)
    );

    smul_shift_add_core #(.N(N)) u_core (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .mcand_mag_i  (mag_a),
        .mplier_mag_i (mag_b),
        .idle_o       (core_idle),
        .done_o       (core_done),
        .raw_o        (core_raw)
    );

    smul_sign_fix #(.N(N)) u_fix (
        .raw_i   (core_raw),
        .neg_i   (r_q.neg),
        .fixed_o (fixed)
    );

    always_comb begin
        r_d      = r_q;
        accept   = start_i && core_idle;
        r_d.done = core_done;
        if (accept) begin
            r_d.neg = sgn_a ^ sgn_b;
        end
        if (core_done) begin
            r_d.product = fixed;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign product_o = r_q.product;
    assign done_o    = r_q.done;

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R2
    AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !core_done |=> $stable(product_o)); // R10
    AST_SIGN_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && product_o != '0) |-> (product_o[PW-1] == r_q.neg)); // R6
    AST_ZERO_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        (core_done && core_raw == '0) |=> (product_o == '0)); // R8

endmodule

// File: tb/smul_top_bench.sv
module smul_top_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #5 clk = ~clk;

    logic       st4 = 1'b0, st8 = 1'b0;
    logic [3:0] a4 = '0, b4 = '0;
    logic [7:0] a8 = '0, b8 = '0;
    logic [7:0]  p4;
    logic [15:0] p8;
    logic        d4, d8;

    int checks = 0;
    int errors = 0;
    logic [15:0] q4[$];
    logic [15:0] q8[$];

    smul_top #(.N(4)) u_smul_top (
        .clk(clk), .rst_n(rst_n), .start_i(st4),
        .mcand_i(a4), .mplier_i(b4), .product_o(p4), .done_o(d4)
    );

    smul_top #(.N(8)) u_smul_top_w8 (
        .clk(clk), .rst_n(rst_n), .start_i(st8),
        .mcand_i(a8), .mplier_i(b8), .product_o(p8), .done_o(d8)
    );

    function automatic string req_of(int a, int b);
        if (a == 0 || b == 0) return "R8";
        if (a > 0 && b > 0)   return "R3";
        if (a < 0 && b > 0)   return "R4";
        if (a > 0 && b < 0)   return "R5";
        return "R6";
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitors: pop the scoreboard on each done pulse.
    always @(negedge clk) begin
        if (rst_n && d4) begin
            if (q4.size() == 0) check(1'b0, "R9", int'(p4), -1);
            else begin
                logic [15:0] e;
                e = q4.pop_front();
                check(p4 == e[7:0], "R3", int'(p4), int'(e[7:0]));
            end
        end
        if (rst_n && d8) begin
            if (q8.size() == 0) check(1'b0, "R9", int'(p8), -1);
            else begin
                logic [15:0] e;
                e = q8.pop_front();
                check(p8 == e, "R3", int'(p8), int'(e));
            end
        end
    end

    // Driver: pushes expectation, pulses start, measures latency (R2),
    // optionally fires a busy strobe (R9) and checks hold (R10).
    task automatic run(bit wide, int a, int b, bit busy_poke);
        int n, lat;
        logic [15:0] exp;
        n   = wide ? 8 : 4;
        exp = 16'(a * b);
        if (!wide) exp = {8'h00, exp[7:0]};
        @(negedge clk);
        if (wide) begin a8 = 8'(a); b8 = 8'(b); st8 = 1'b1; q8.push_back(exp); end
        else      begin a4 = 4'(a); b4 = 4'(b); st4 = 1'b1; q4.push_back(exp); end
        lat = 0;
        @(negedge clk);
        lat++;
        st4 = 1'b0; st8 = 1'b0;
        if (busy_poke) begin
            if (wide) begin a8 = 8'(-a + 3); b8 = 8'(7); st8 = 1'b1; end
            else      begin a4 = 4'(-a + 3); b4 = 4'(7); st4 = 1'b1; end
        end
        while (!(wide ? d8 : d4) && lat < 40) begin
            @(negedge clk);
            lat++;
            st4 = 1'b0; st8 = 1'b0;
        end
        check(lat == n + 2, "R2", lat, n + 2);
        @(negedge clk);
        check(!(wide ? d8 : d4), "R2", int'(wide ? d8 : d4), 0);
        if (busy_poke || (a == 0) || (b == 0)) begin
            for (int k = 0; k < n + 3; k++) @(negedge clk);
            check((wide ? p8 : {8'h00, p4}) == exp, busy_poke ? "R10" : req_of(a, b),
                  int'(wide ? p8 : {8'h00, p4}), int'(exp));
            if (busy_poke) check((wide ? q8.size() : q4.size()) == 0, "R9",
                                 wide ? q8.size() : q4.size(), 0);
        end
    endtask

    initial begin
        #2_000_000;
        errors++;
        checks++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        check(p4 == 8'h00 && !d4, "R1", int'(p4), 0);
        check(p8 == 16'h0000 && !d8, "R1", int'(p8), 0);
        rst_n = 1'b1;

        // Exhaustive N=4: all sign combos (R3..R6), zeros (R8), min value (R7).
        for (int a = -8; a < 8; a++)
            for (int b = -8; b < 8; b++)
                run(1'b0, a, b, 1'b0);

        // R7 explicit: (-8)*(-8) = 64
        run(1'b0, -8, -8, 1'b0);
        check(p4 == 8'd64, "R7", int'(p4), 64);

        // R9/R10: busy strobes ignored, product held
        run(1'b0, -3, 5, 1'b1);
        run(1'b0, 7, 7, 1'b1);

        // N=8 corners
        run(1'b1, -128, -128, 1'b0);
        check(p8 == 16'd16384, "R7", int'(p8), 16384);
        run(1'b1, -128, 127, 1'b0);
        check(p8 == 16'(-16256), "R7", int'(p8), -16256);
        run(1'b1, 0, -77, 1'b0);
        run(1'b1, -1, 0, 1'b0);
        run(1'b1, 127, 127, 1'b0);
        run(1'b1, -100, 3, 1'b0);
        run(1'b1, 45, -90, 1'b1);

        lfsr = 16'hACE1;
        for (int i = 0; i < 200; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            run(1'b1, int'($signed(lfsr[7:0])), int'($signed(lfsr[15:8])), 1'b0);
        end

        repeat (20) @(negedge clk);
        check(q4.size() == 0 && q8.size() == 0, "R2", q4.size() + q8.size(), 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule